// File: doc/BRIEF.md
# Control-Bit Driven 16-bit Arithmetic Logic Unit

This block is a combinational arithmetic logic unit for two 16-bit two's-complement operands. It has no opcode decoder. Six separate control bits shape the computation directly:

- Each operand can be cleared and can be inverted on its own.
- The core step is either a sum or a bitwise AND of the two conditioned operands.
- The core result can be inverted before it reaches the output.

Combining these bits gives eighteen useful functions: constants, pass-through, negation, increment, decrement, sum, both differences, AND and OR.

Two status flags come with the result: one marks a zero result and one marks a negative result. The sum is built from a chain of one-bit adder cells in which each carry ripples to the next stage. Addition wraps modulo 2^16, and no overflow or carry indication leaves the block. The result and flags follow the inputs in the same cycle, so the block fits inside a datapath between registers owned by the surrounding logic.

Top module: `ctl_alu16`

## Requirements
- R1: The result and both flags are combinational functions of the present inputs. They settle within the same cycle that the inputs change, with no register on the path.
- R2: When `clr_a` is 1, operand A is replaced by zero before any other conditioning. `clr_b` does the same for operand B.
- R3: When `inv_a` is 1, the (possibly cleared) operand A is inverted bit by bit. `inv_b` does the same for operand B.
- R4: Clearing happens before inversion. Setting both the clear bit and the invert bit of one operand yields 16'hFFFF (-1) for that operand.
- R5: With `sel_add` = 1, the core result is the 16-bit sum of the conditioned operands, taken modulo 2^16. Wrap-around is not reported on any port.
- R6: With `sel_add` = 0, the core result is the bitwise AND of the conditioned operands.
- R7: With `inv_res` = 1, `res_out` is the bitwise inverse of the core result. Otherwise `res_out` equals the core result.
- R8: `flag_zero` is 1 exactly when `res_out` is 16'h0000. It is evaluated after the output inversion.
- R9: `flag_neg` equals bit 15 of `res_out`, which is its two's-complement sign.
- R10: The control word {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res} = 6'b010011 gives A minus B. For example, A = 7 and B = 5 give 2.
- R11: Eighteen control words, listed as {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res}, give the functions below:

  | Control word | Function |
  |---|---|
  | 101010 | 0 |
  | 111111 | 1 |
  | 111010 | -1 |
  | 001100 | A |
  | 110000 | B |
  | 001101 | ~A |
  | 110001 | ~B |
  | 001111 | -A |
  | 110011 | -B |
  | 011111 | A+1 |
  | 110111 | B+1 |
  | 001110 | A-1 |
  | 110010 | B-1 |
  | 000010 | A+B |
  | 010011 | A-B |
  | 000111 | B-A |
  | 000000 | A&B |
  | 010101 | A\|B |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | Operand A, two's complement |
| b_in | input | 16 | Operand B, two's complement |
| clr_a | input | 1 | Replace operand A with zero |
| inv_a | input | 1 | Invert operand A bit by bit |
| clr_b | input | 1 | Replace operand B with zero |
| inv_b | input | 1 | Invert operand B bit by bit |
| sel_add | input | 1 | 1 selects sum, 0 selects bitwise AND |
| inv_res | input | 1 | Invert the core result |
| res_out | output | 16 | Result |
| flag_zero | output | 1 | Result equals zero |
| flag_neg | output | 1 | Result is negative |

## Verification
Several functions meet in one evaluation when a carry runs across all sixteen stages:

- the sum has to wrap to zero;
- the output inversion turns that zero into all ones;
- the two flags then have to swap.

The bench provokes this with operands such as 16'hFFFF plus 1 and 16'h8000 plus 16'h8000, under control words with and without output inversion. It judges the outcome against arithmetic computed independently for each of the eighteen named functions. Random operands under all 64 control words are compared with a model built from the conditioning rules, which covers the operand clear-then-invert ordering in the same pass.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;
  parameter int unsigned ALU_W = 16;

  typedef struct packed {
    logic clr_a;
    logic inv_a;
    logic clr_b;
    logic inv_b;
    logic sel_add;
    logic inv_res;
  } alu_ctl_t;
endpackage

// File: rtl/alu_opnd_cond.sv
module alu_opnd_cond #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] d_in,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] q_out
);
  logic [W-1:0] cleared;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign cleared[i] = d_in[i] & ~clr;
      assign q_out[i]   = cleared[i] ^ inv;
    end
  endgenerate

  always_comb begin
    if (clr) begin
      AST_CLR_THEN_INV: assert (q_out == {W{inv}})
        else $error("cleared operand not constant"); // R4
    end
  end
endmodule

// File: rtl/alu_half_add.sv
module alu_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (ci & p);
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_lsb
        alu_half_add u_ha (
          .a  (a[i]),
          .b  (b[i]),
          .s  (sum[i]),
          .co (carry[i])
        );
      end else begin : g_upper
        alu_full_add u_fa (
          .a  (a[i]),
          .b  (b[i]),
          .ci (carry[i-1]),
          .s  (sum[i]),
          .co (carry[i])
        );
      end
    end
  endgenerate

  always_comb begin
    AST_RIPPLE_SUM: assert ({carry[W-1], sum} == ({1'b0, a} + {1'b0, b}))
      else $error("ripple chain disagrees with arithmetic sum"); // R5
  end
endmodule

// File: rtl/ctl_alu16.sv
module ctl_alu16
  import ctl_alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_add,
  input  logic         inv_res,
  output logic [W-1:0] res_out,
  output logic         flag_zero,
  output logic         flag_neg
);
  localparam int unsigned MSB = W - 1;

  alu_ctl_t     ctl;
  logic [W-1:0] a_c;
  logic [W-1:0] b_c;
  logic [W-1:0] sum_w;
  logic [W-1:0] and_w;
  logic [W-1:0] core_w;

  assign ctl = '{clr_a: clr_a, inv_a: inv_a, clr_b: clr_b, inv_b: inv_b,
                 sel_add: sel_add, inv_res: inv_res};

  alu_opnd_cond #(.W(W)) u_cond_a (
    .d_in  (a_in),
    .clr   (ctl.clr_a),
    .inv   (ctl.inv_a),
    .q_out (a_c)
  );

  alu_opnd_cond #(.W(W)) u_cond_b (
    .d_in  (b_in),
    .clr   (ctl.clr_b),
    .inv   (ctl.inv_b),
    .q_out (b_c)
  );

  alu_ripple_add #(.W(W)) u_add (
    .a   (a_c),
    .b   (b_c),
    .sum (sum_w)
  );

  assign and_w     = a_c & b_c;
  assign core_w    = ctl.sel_add ? sum_w : and_w;
  assign res_out   = core_w ^ {W{ctl.inv_res}};
  assign flag_zero = ~|res_out;
  assign flag_neg  = res_out[MSB];

  always_comb begin
    AST_FLAGS_EXCL: assert (!(flag_zero && flag_neg))
      else $error("zero and negative flags both set"); // R8
    if (!ctl.sel_add) begin
      AST_AND_SUBSET: assert (((core_w & ~a_c) | (core_w & ~b_c)) == '0)
        else $error("AND result has bit outside operands"); // R6
    end
    if (ctl.clr_a && ctl.clr_b && !ctl.inv_a && !ctl.inv_b) begin
      AST_ZERO_OPNDS: assert (res_out == {W{ctl.inv_res}})
        else $error("two cleared operands gave wrong result"); // R2
    end
  end
endmodule

// File: tb/sim_ctl_alu16.sv
module sim_ctl_alu16;
  logic        clk = 1'b0;
  logic [15:0] a_in, b_in, res_out;
  logic        clr_a, inv_a, clr_b, inv_b, sel_add, inv_res;
  logic        flag_zero, flag_neg;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  always #2 clk = ~clk;

  ctl_alu16 u0 (
    .a_in(a_in), .b_in(b_in), .clr_a(clr_a), .inv_a(inv_a),
    .clr_b(clr_b), .inv_b(inv_b), .sel_add(sel_add), .inv_res(inv_res),
    .res_out(res_out), .flag_zero(flag_zero), .flag_neg(flag_neg)
  );

  localparam logic [5:0] CODES [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};

  // Rule-based model, control word {clr_a,inv_a,clr_b,inv_b,sel_add,inv_res}
  function automatic logic [15:0] rule_model(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    logic [15:0] xa, yb, k;
    xa = c[5] ? 16'h0000 : x;
    xa = c[4] ? ~xa : xa;
    yb = c[3] ? 16'h0000 : y;
    yb = c[2] ? ~yb : yb;
    k  = c[1] ? 16'(xa + yb) : (xa & yb);
    return c[0] ? ~k : k;
  endfunction

  // Meaning of the eighteen named words
  function automatic logic [15:0] named_fn(int idx, logic [15:0] x, logic [15:0] y);
    case (idx)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return x;
      4: return y;
      5: return ~x;
      6: return ~y;
      7: return 16'(-x);
      8: return 16'(-y);
      9: return 16'(x + 1);
      10: return 16'(y + 1);
      11: return 16'(x - 1);
      12: return 16'(y - 1);
      13: return 16'(x + y);
      14: return 16'(x - y);
      15: return 16'(y - x);
      16: return x & y;
      default: return x | y;
    endcase
  endfunction

  task automatic drive(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res} = c;
    a_in = x;
    b_in = y;
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic [15:0] exp);
    chk(req, res_out, exp);
    chk({req, " R8 zero flag"}, {15'd0, flag_zero}, {15'd0, exp == 16'h0000});
    chk({req, " R9 neg flag"}, {15'd0, flag_neg}, {15'd0, exp[15]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] corners [6];
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h5555};
    void'($urandom(32'h00C0FFEE));
    {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res} = 6'b000000;
    a_in = 16'h0000;
    b_in = 16'h0000;

    // R1: all-zero inputs with AND gives zero, flags settled in the same cycle
    drive(6'b000000, 16'h0000, 16'h0000);
    chk_all("R1 idle inputs", 16'h0000);

    // R10: the worked subtraction example
    drive(6'b010011, 16'h0007, 16'h0005);
    chk_all("R10 7-5", 16'h0002);

    // R4: clear plus invert on both sides, AND core -> all ones
    drive(6'b111100, 16'h1234, 16'hABCD);
    chk_all("R4 clear then invert", 16'hFFFF);

    // R2: cleared A under AND gives zero regardless of B
    drive(6'b100000, 16'hFFFF, 16'hFFFF);
    chk_all("R2 clear A", 16'h0000);
    drive(6'b001000, 16'hFFFF, 16'hFFFF);
    chk_all("R2 clear B", 16'h0000);

    // R3: invert A alone under AND with all-ones B
    drive(6'b010000, 16'h0F0F, 16'hFFFF);
    chk_all("R3 invert A", 16'hF0F0);
    drive(6'b000100, 16'hFFFF, 16'h00FF);
    chk_all("R3 invert B", 16'hFF00);

    // R5: full-width carry wraps to zero, no overflow visible
    drive(6'b000010, 16'hFFFF, 16'h0001);
    chk_all("R5 wrap FFFF+1", 16'h0000);
    drive(6'b000010, 16'h8000, 16'h8000);
    chk_all("R5 wrap 8000+8000", 16'h0000);
    drive(6'b000010, 16'h7FFF, 16'h0001);
    chk_all("R5 signed wrap", 16'h8000);

    // R7: the same wrapped sum inverted swaps the flags
    drive(6'b000011, 16'hFFFF, 16'h0001);
    chk_all("R7 inverted wrap", 16'hFFFF);

    // R6: AND core
    drive(6'b000000, 16'hC3A5, 16'h0FF0);
    chk_all("R6 AND", 16'h03A0);

    // R11: named functions over corner operands
    for (int k = 0; k < 18; k++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          drive(CODES[k], corners[i], corners[j]);
          chk_all($sformatf("R11 word %b corner", CODES[k]), named_fn(k, corners[i], corners[j]));
        end
      end
    end

    // R11: named functions over random operands
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 18; k++) begin
        logic [15:0] x, y;
        x = 16'($urandom);
        y = 16'($urandom);
        drive(CODES[k], x, y);
        chk_all($sformatf("R11 word %b random", CODES[k]), named_fn(k, x, y));
      end
    end

    // R2 R3 R4 R5 R6 R7: every control word against the rule model
    for (int n = 0; n < 30; n++) begin
      for (int c = 0; c < 64; c++) begin
        logic [15:0] x, y;
        x = 16'($urandom);
        y = 16'($urandom);
        drive(6'(c), x, y);
        chk_all($sformatf("R2-rule R7-rule word %b", 6'(c)), rule_model(6'(c), x, y));
      end
    end

    finish_run();
  end
endmodule